// File: doc/BRIEF.md
# Three-Channel Interval Timer Bus Interface

This block sits between a byte-wide register bus and three interval-timer counting cores. A 2-bit address picks one of three channel data ports (0, 1, 2) or the control port (3). Control words written to port 3 either configure a channel or capture state: a count snapshot, a status snapshot, or both, for one channel or for several at once. Each channel keeps its own access width, operating mode and BCD flag, as well as byte-toggle state for writes and for reads. Each channel can hold one pending count snapshot and one pending status snapshot.

Each core gets from this block its operating mode, a one-cycle load strobe and the 16-bit initial count. Each core returns its live count and its output level. A count of zero is passed through unchanged. The counting cores interpret a zero count, and BCD arithmetic is also their concern.

Read data is combinational: `rdata` is valid in the same cycle as `rd_en`. All side effects of a read (clearing a snapshot, advancing a toggle) take effect at the clock edge that ends that cycle. Write effects, including the load strobe, appear in the cycle after the write.

Top module: `itmr_busif`

## Requirements
- R1: After reset, every channel uses low-then-high access in mode 0 with the BCD flag clear. No load strobe is active, every initial count is zero, and no snapshot is pending.
- R2: A read at address 3 returns 8'h00. With `rd_en` low, `rdata` is 8'h00.
- R3: A control word decodes as follows. Bits 7:6 are the target channel (3 means readback). Bits 5:4 are the access code. Bits 3:1 are the operating mode and bit 0 is the BCD flag. When the access code is non-zero, the mode appears on that channel's `ch_mode` in the next cycle.
- R4: Access code 01 (low only): each data write loads {8'h00, byte} and pulses that channel's `ch_load` for one cycle, in the cycle after the write.
- R5: Access code 10 (high only): each data write loads {byte, 8'h00} with a load strobe.
- R6: Access code 11 (low then high): the first data write only holds the byte, with no strobe. The second write loads {second, first} with a strobe. The toggle then expects a low byte again.
- R7: A control word with a non-zero access code resets both byte toggles of its channel to expect the low byte.
- R8: Unlatched reads return the live count. Access 01 gives the low byte every time, access 10 gives the high byte every time, and access 11 alternates low, high, low, starting with low.
- R9: Access code 00 is a count-latch command. It captures the live count. Later reads return the snapshot, low byte then high byte in mode 11, and the snapshot is released after the high byte.
- R10: A count-latch request while a snapshot is still unread is ignored. The earlier value is kept.
- R11: In a readback word (bits 7:6 = 11), bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 low latches the count of each selected channel. Unselected channels are not affected.
- R12: In a readback word, bit 4 low latches the status byte {out level, 0, access code, mode, BCD}. A pending status is not overwritten. A data read returns the pending status first and clears it, then the count snapshot, then the live count.
- R13: In single-byte access modes, a count snapshot is released after one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 2 | 0..2 channel data port, 3 control port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of `rd_en` |
| ch_live | input | 48 | Live count of each core, channel i at [16i+15:16i] |
| ch_out | input | 3 | Output level of each core |
| ch_mode | output | 9 | Operating mode per channel, channel i at [3i+2:3i] |
| ch_load | output | 3 | One-cycle load strobe per channel |
| ch_count | output | 48 | Initial count per channel, channel i at [16i+15:16i] |

## Verification
A stuck or wrong byte toggle shows up at `ch_count` and `ch_load` on the next data write. It also shows in the order of bytes on `rdata` within two reads. A snapshot that is captured twice, or released too early or too late, is exposed on the first read after the live count is changed on purpose. The live count is moved between the latch command and the read for exactly this reason. A status byte that is lost or overwritten shows on the first read of the channel, because the output level is changed before a second status request.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int NCH    = 3;
  localparam int ADDR_W = 2;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_WORD  = 2'b11
  } acc_e;

  function automatic logic [BYTE_W-1:0] f_status(input logic lvl, input acc_e acc,
                                                 input logic [MODE_W-1:0] mode,
                                                 input logic bcd);
    return {lvl, 1'b0, acc, mode, bcd};
  endfunction

  function automatic logic [CNT_W-1:0] f_load_value(input acc_e acc,
                                                    input logic [BYTE_W-1:0] b,
                                                    input logic [BYTE_W-1:0] held);
    case (acc)
      ACC_LO:  return {{BYTE_W{1'b0}}, b};
      ACC_HI:  return {b, {BYTE_W{1'b0}}};
      default: return {b, held};
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] f_pick(input logic [CNT_W-1:0] v, input logic hi);
    return hi ? v[CNT_W-1:BYTE_W] : v[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/itmr_cmd_dec.sv
module itmr_cmd_dec
  import itmr_pkg::*;
(
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:1]        cw,
  output logic [NCH-1:0]    ev_ctl,
  output logic [NCH-1:0]    ev_latch,
  output logic [NCH-1:0]    ev_stat,
  output logic [NCH-1:0]    ev_dwr,
  output logic [NCH-1:0]    ev_drd
);
  localparam logic [ADDR_W-1:0] CTL_PORT = ADDR_W'(NCH);

  logic ctl_wr, rb_cmd;
  assign ctl_wr = wr_en && (addr == CTL_PORT);
  assign rb_cmd = ctl_wr && (cw[7:6] == 2'b11);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic tgt;
    assign tgt         = ctl_wr && (cw[7:6] == 2'(i));
    assign ev_ctl[i]   = tgt && (cw[5:4] != ACC_LATCH);
    assign ev_latch[i] = (tgt && (cw[5:4] == ACC_LATCH)) || (rb_cmd && cw[i+1] && !cw[5]);
    assign ev_stat[i]  = rb_cmd && cw[i+1] && !cw[4];
    assign ev_dwr[i]   = wr_en && (addr == ADDR_W'(i));
    assign ev_drd[i]   = rd_en && (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/itmr_chan.sv
module itmr_chan
  import itmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_ctl,
  input  logic              ev_latch,
  input  logic              ev_stat,
  input  logic              ev_dwr,
  input  logic              ev_drd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live,
  input  logic              out_lvl,
  output logic [MODE_W-1:0] mode,
  output logic              load,
  output logic [CNT_W-1:0]  init_cnt,
  output logic [BYTE_W-1:0] rbyte,
  output logic [1:0]        acc_o,
  output logic              stat_pend,
  output logic              clat_busy,
  output logic              wr_hi,
  output logic              rd_hi,
  output logic [CNT_W-1:0]  lat_val,
  output logic [BYTE_W-1:0] stat_val
);
  acc_e acc_q, clat_q;
  logic bcd_q;
  logic [BYTE_W-1:0] wlat_q;

  assign acc_o     = acc_q;
  assign clat_busy = (clat_q != ACC_LATCH);

  always_comb begin
    if (stat_pend)      rbyte = stat_val;
    else if (clat_busy) rbyte = f_pick(lat_val, clat_q == ACC_HI);
    else                rbyte = f_pick(live, (acc_q == ACC_HI) || (acc_q == ACC_WORD && rd_hi));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= ACC_WORD;
      mode      <= '0;
      bcd_q     <= 1'b0;
      wr_hi     <= 1'b0;
      rd_hi     <= 1'b0;
      wlat_q    <= '0;
      clat_q    <= ACC_LATCH;
      lat_val   <= '0;
      stat_pend <= 1'b0;
      stat_val  <= '0;
      load      <= 1'b0;
      init_cnt  <= '0;
    end else begin
      load <= 1'b0;
      if (ev_latch && !clat_busy) begin
        clat_q  <= acc_q;
        lat_val <= live;
      end
      if (ev_stat && !stat_pend) begin
        stat_pend <= 1'b1;
        stat_val  <= f_status(out_lvl, acc_q, mode, bcd_q);
      end
      if (ev_dwr) begin
        if (acc_q == ACC_WORD && !wr_hi) begin
          wlat_q <= wdata;
          wr_hi  <= 1'b1;
        end else begin
          init_cnt <= f_load_value(acc_q, wdata, wlat_q);
          load     <= 1'b1;
          wr_hi    <= 1'b0;
        end
      end
      if (ev_drd) begin
        if (stat_pend)           stat_pend <= 1'b0;
        else if (clat_busy)      clat_q <= (clat_q == ACC_WORD) ? ACC_HI : ACC_LATCH;
        else if (acc_q == ACC_WORD) rd_hi <= !rd_hi;
      end
      if (ev_ctl) begin
        acc_q <= acc_e'(wdata[5:4]);
        mode  <= wdata[3:1];
        bcd_q <= wdata[0];
        wr_hi <= 1'b0;
        rd_hi <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/itmr_busif.sv
module itmr_busif
  import itmr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [BYTE_W-1:0]     wdata,
  output logic [BYTE_W-1:0]     rdata,
  input  logic [NCH*CNT_W-1:0]  ch_live,
  input  logic [NCH-1:0]        ch_out,
  output logic [NCH*MODE_W-1:0] ch_mode,
  output logic [NCH-1:0]        ch_load,
  output logic [NCH*CNT_W-1:0]  ch_count
);
  logic [NCH-1:0] ev_ctl, ev_latch, ev_stat, ev_dwr, ev_drd;
  logic [NCH-1:0] stat_pend, clat_busy, wr_hi, rd_hi;
  logic [NCH*2-1:0] acc_all;
  logic [NCH*CNT_W-1:0] lat_val;
  logic [NCH*BYTE_W-1:0] stat_val;
  logic [NCH*BYTE_W-1:0] rbyte_all;

  itmr_cmd_dec u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .cw(wdata[7:1]),
    .ev_ctl(ev_ctl), .ev_latch(ev_latch), .ev_stat(ev_stat),
    .ev_dwr(ev_dwr), .ev_drd(ev_drd)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    itmr_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .ev_ctl(ev_ctl[i]), .ev_latch(ev_latch[i]), .ev_stat(ev_stat[i]),
      .ev_dwr(ev_dwr[i]), .ev_drd(ev_drd[i]), .wdata(wdata),
      .live(ch_live[i*CNT_W +: CNT_W]), .out_lvl(ch_out[i]),
      .mode(ch_mode[i*MODE_W +: MODE_W]), .load(ch_load[i]),
      .init_cnt(ch_count[i*CNT_W +: CNT_W]),
      .rbyte(rbyte_all[i*BYTE_W +: BYTE_W]), .acc_o(acc_all[i*2 +: 2]),
      .stat_pend(stat_pend[i]), .clat_busy(clat_busy[i]),
      .wr_hi(wr_hi[i]), .rd_hi(rd_hi[i]),
      .lat_val(lat_val[i*CNT_W +: CNT_W]), .stat_val(stat_val[i*BYTE_W +: BYTE_W])
    );
  end

  always_comb begin
    rdata = '0;
    if (rd_en && (int'(addr) < NCH)) rdata = rbyte_all[int'(addr)*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/itmr_busif_chk.sv
module itmr_busif_chk
  import itmr_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rd_en,
  input logic [ADDR_W-1:0]     addr,
  input logic [BYTE_W-1:0]     rdata,
  input logic [NCH-1:0]        ch_load,
  input logic [NCH-1:0]        ev_ctl,
  input logic [NCH-1:0]        ev_stat,
  input logic [NCH-1:0]        ev_dwr,
  input logic [NCH-1:0]        ev_drd,
  input logic [NCH-1:0]        stat_pend,
  input logic [NCH-1:0]        clat_busy,
  input logic [NCH-1:0]        wr_hi,
  input logic [NCH-1:0]        rd_hi,
  input logic [NCH*2-1:0]      acc_all,
  input logic [NCH*CNT_W-1:0]  lat_val,
  input logic [NCH*BYTE_W-1:0] stat_val
);
  p_ctl_port_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd3) |-> rdata == 8'h00);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_load_from_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ch_load[i] |-> $past(ev_dwr[i]));
    p_word_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_dwr[i] && acc_all[i*2 +: 2] == 2'b11 && !wr_hi[i]) |=> !ch_load[i]);
    p_ctl_clears_toggles_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_ctl[i] |=> (!wr_hi[i] && !rd_hi[i]));
    p_latch_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(clat_busy[i]) && clat_busy[i]) |-> $stable(lat_val[i*CNT_W +: CNT_W]));
    p_status_kept_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stat_pend[i]) && stat_pend[i]) |-> $stable(stat_val[i*BYTE_W +: BYTE_W]));
    p_status_read_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_drd[i] && stat_pend[i] && !ev_stat[i]) |=> !stat_pend[i]);
  end
endmodule

bind itmr_busif itmr_busif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .ch_load(ch_load), .ev_ctl(ev_ctl), .ev_stat(ev_stat), .ev_dwr(ev_dwr),
  .ev_drd(ev_drd), .stat_pend(stat_pend), .clat_busy(clat_busy),
  .wr_hi(wr_hi), .rd_hi(rd_hi), .acc_all(acc_all), .lat_val(lat_val),
  .stat_val(stat_val)
);

// File: tb/itmr_busif_test.sv
module itmr_busif_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00, rdata;
  logic [15:0] live [3];
  logic [2:0] ch_out = 3'b000;
  logic [8:0] ch_mode;
  logic [2:0] ch_load;
  logic [47:0] ch_count;
  logic [47:0] ch_live;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  assign ch_live = {live[2], live[1], live[0]};

  itmr_busif uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ch_live(ch_live), .ch_out(ch_out),
    .ch_mode(ch_mode), .ch_load(ch_load), .ch_count(ch_count)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic brd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  // R1 reset state; R2 control-port read; R8 word-mode alternation
  task automatic t_reset;
    logic [7:0] d;
    chk("R1 load idle", {13'd0, ch_load}, 16'h0);
    chk("R1 modes zero", {7'd0, ch_mode}, 16'h0);
    chk("R1 count zero", ch_count[15:0] | ch_count[31:16] | ch_count[47:32], 16'h0);
    chk("R2 rdata idle", {8'h0, rdata}, 16'h0);
    live[0] = 16'h1234;
    brd(2'd0, d); chk("R1 R8 word low first", {8'h0, d}, 16'h0034);
    brd(2'd0, d); chk("R8 word high second", {8'h0, d}, 16'h0012);
    brd(2'd0, d); chk("R8 word low again", {8'h0, d}, 16'h0034);
    brd(2'd3, d); chk("R2 control read zero", {8'h0, d}, 16'h0);
  endtask

  // R3 decode, R4 low-only load, R8 fixed low byte
  task automatic t_lsb;
    logic [7:0] d;
    bwr(2'd3, 8'h54);                     // ch1, acc 01, mode 2
    chk("R3 ch1 mode", {13'd0, ch_mode[5:3]}, 16'd2);
    bwr(2'd1, 8'hAB);
    chk("R4 strobe", {13'd0, ch_load}, 16'b010);
    chk("R4 count", ch_count[31:16], 16'h00AB);
    @(negedge clk);
    chk("R4 one cycle", {13'd0, ch_load}, 16'h0);
    live[1] = 16'h5678;
    brd(2'd1, d); chk("R8 low only 1", {8'h0, d}, 16'h0078);
    brd(2'd1, d); chk("R8 low only 2", {8'h0, d}, 16'h0078);
  endtask

  // R5 high-only load, R8 fixed high byte
  task automatic t_msb;
    logic [7:0] d;
    bwr(2'd3, 8'hA6);                     // ch2, acc 10, mode 3
    chk("R3 ch2 mode", {13'd0, ch_mode[8:6]}, 16'd3);
    bwr(2'd2, 8'hCD);
    chk("R5 strobe", {13'd0, ch_load}, 16'b100);
    chk("R5 count", ch_count[47:32], 16'hCD00);
    live[2] = 16'h9A0F;
    brd(2'd2, d); chk("R8 high only 1", {8'h0, d}, 16'h009A);
    brd(2'd2, d); chk("R8 high only 2", {8'h0, d}, 16'h009A);
  endtask

  // R6 two-byte write sequencing
  task automatic t_word;
    bwr(2'd3, 8'h38);                     // ch0, acc 11, mode 4
    chk("R3 ch0 mode", {13'd0, ch_mode[2:0]}, 16'd4);
    bwr(2'd0, 8'h11);
    chk("R6 no strobe on low", {13'd0, ch_load}, 16'h0);
    bwr(2'd0, 8'h22);
    chk("R6 strobe on high", {13'd0, ch_load}, 16'b001);
    chk("R6 count", ch_count[15:0], 16'h2211);
    bwr(2'd0, 8'h33);
    chk("R6 toggle back", {13'd0, ch_load}, 16'h0);
    bwr(2'd0, 8'h44);
    chk("R6 second count", ch_count[15:0], 16'h4433);
  endtask

  // R7 control word resets toggles
  task automatic t_toggle_reset;
    logic [7:0] d;
    bwr(2'd0, 8'h55);
    bwr(2'd3, 8'h38);
    bwr(2'd0, 8'h66);
    chk("R7 write toggle reset", {13'd0, ch_load}, 16'h0);
    bwr(2'd0, 8'h77);
    chk("R7 count after reset", ch_count[15:0], 16'h7766);
    live[0] = 16'hA1B2;
    brd(2'd0, d);
    bwr(2'd3, 8'h38);
    brd(2'd0, d); chk("R7 read toggle reset", {8'h0, d}, 16'h00B2);
  endtask

  // R9 word latch, R10 second latch ignored
  task automatic t_latch;
    logic [7:0] d;
    bwr(2'd3, 8'h38);
    live[0] = 16'hBEEF;
    bwr(2'd3, 8'h00);
    live[0] = 16'h1111;
    bwr(2'd3, 8'h00);
    live[0] = 16'h2233;
    brd(2'd0, d); chk("R9 R10 latched low", {8'h0, d}, 16'h00EF);
    brd(2'd0, d); chk("R9 R10 latched high", {8'h0, d}, 16'h00BE);
    brd(2'd0, d); chk("R9 released to live", {8'h0, d}, 16'h0033);
  endtask

  // R13 single-byte latch release
  task automatic t_latch_single;
    logic [7:0] d;
    live[1] = 16'h0A0B;
    bwr(2'd3, 8'h40);
    live[1] = 16'h0C0D;
    brd(2'd1, d); chk("R13 latched byte", {8'h0, d}, 16'h000B);
    brd(2'd1, d); chk("R13 released", {8'h0, d}, 16'h000D);
  endtask

  // R11 multi-channel readback count latch
  task automatic t_readback;
    logic [7:0] d;
    bwr(2'd3, 8'h38);
    live[0] = 16'h1357; live[1] = 16'h4455; live[2] = 16'h2468;
    bwr(2'd3, 8'hDA);                     // count only, ch0 and ch2
    live[0] = 16'h0000; live[1] = 16'h6677; live[2] = 16'h0000;
    brd(2'd0, d); chk("R11 ch0 low", {8'h0, d}, 16'h0057);
    brd(2'd0, d); chk("R11 ch0 high", {8'h0, d}, 16'h0013);
    brd(2'd2, d); chk("R11 ch2 high", {8'h0, d}, 16'h0024);
    brd(2'd1, d); chk("R11 ch1 untouched", {8'h0, d}, 16'h0077);
  endtask

  // R12 status latch, keep, priority
  task automatic t_status;
    logic [7:0] d;
    ch_out[2] = 1'b1;
    bwr(2'd3, 8'hE8);                     // status only, ch2
    ch_out[2] = 1'b0;
    bwr(2'd3, 8'hE8);                     // must not overwrite
    live[2] = 16'h9ABC;
    bwr(2'd3, 8'hD8);                     // count only, ch2
    live[2] = 16'h4321;
    brd(2'd2, d); chk("R12 status first", {8'h0, d}, 16'h00A6);
    brd(2'd2, d); chk("R12 count second", {8'h0, d}, 16'h009A);
    brd(2'd2, d); chk("R12 live third", {8'h0, d}, 16'h0043);
  endtask

  initial begin
    live[0] = '0; live[1] = '0; live[2] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_lsb();
    t_msb();
    t_word();
    t_toggle_reset();
    t_latch();
    t_latch_single();
    t_readback();
    t_status();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule